// File: doc/BRIEF.md
# Six-Phase Polyphase Decimating FIR

This block lowers the sample rate of a signed stream by six while applying a 60-tap low-pass response. Each accepted input sample carries a strobe. A commutator hands the samples of each group of six to six phase branches. Each branch is a 10-tap filter, and all branches are clocked by one shared clock. A branch does work only on an enable pulse that the commutator raises once per completed group, so the multiply-add hardware updates at one sixth of the input rate without a second clock.

The six branch sums are added, rounded from Q15 back to 16 bits, saturated, and presented with a one-cycle valid pulse. Coefficients are elaboration-time constants computed from a closed formula. A 2-flop synchronizer releases the asynchronous active-low reset on a clock edge.

Top module: `decim6_polyfir`

## Requirements
- R1: Exactly one `out_valid` pulse, one cycle wide, is produced for every six accepted inputs (cycles with `in_valid` high). No pulse appears otherwise.
- R2: Cycles with `in_valid` low have no effect:
  - the group position does not advance;
  - the filter history is unchanged;
  - the output values equal those of the same samples sent without gaps.
- R3: Accepted samples are numbered x[0], x[1], … from reset. Within a group, the first sample goes to branch 5 and the last sample goes to branch 0. The output for the group ending at sample n therefore equals y[n] = Σ_{k=0..59} h[k]·x[n−k], taking x[i]=0 for i<0. Outputs exist only at n = 5, 11, 17, …
- R4: Prototype tap k (0..59) is h[k] = (((97·k + 13) mod 181) − 90)·300. Branch p holds taps p, p+6, …, p+54.
- R5: The 38-bit sum is rounded half-up by adding 2^14 and then arithmetic-shifting right by 15. The result is clamped to the range −32768..32767.
- R6: Suppose the clock edge that accepts the sixth sample of a group is edge 0. Then `out_valid` is high between edge 3 and edge 4, and `out_data` holds the result from edge 3 until the next result.
- R7: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0. A reset in the middle of a group clears the group position and all branch history.
- R8: Groups that arrive back to back, with `in_valid` held high continuously, are each filtered correctly and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse per decimated result |
| out_data | output | 16 | Signed, rounded and saturated result |

## Verification
The commutator order is tested with single impulses placed at the first and at the last position of a group. A design that steers samples in ascending order would give the right output count but a time-reversed set of branch taps, so the impulse responses would come out of place. A 60-sample input whose signs match the coefficients drives the sum far past full scale in both directions. Missing saturation would then show up as a wrapped value, and a rounding error as a one-LSB offset in the table vectors. Gapped strobes, a reset in the middle of a group and continuous back-to-back groups catch a counter that advances on idle cycles, history that survives reset, and a pipeline that drops a group or slips its three-edge latency.

// File: rtl/decim6_pkg.sv
package decim6_pkg;

  // Default geometry of the decimator
  localparam int PHASES_DEF   = 6;
  localparam int TAPS_PER_DEF = 10;

  // Prototype low-pass tap k, Q15 scaling, computed instead of tabulated
  function automatic int proto_coef(input int k);
    return (((k * 97 + 13) % 181) - 90) * 300;
  endfunction

endpackage

// File: rtl/decim6_commutator.sv
module decim6_commutator #(
  parameter int PHASES = 6,
  parameter int DW     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic        [DW-1:0]         in_data,
  output logic                         grp_en,
  output logic [PHASES-1:0][DW-1:0]    grp_data
);

  localparam int PHW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PHW-1:0] LAST = PHW'(PHASES - 1);

  logic [PHW-1:0]               phase_q, phase_d;
  logic [PHASES-1:1][DW-1:0]    hold_q,  hold_d;
  logic [PHASES-1:0][DW-1:0]    grp_q,   grp_d;
  logic                         en_q,    en_d;

  // Next state: group position k feeds branch LAST-k
  always_comb begin
    phase_d = phase_q;
    hold_d  = hold_q;
    grp_d   = grp_q;
    en_d    = 1'b0;
    if (in_valid) begin
      if (phase_q == LAST) begin
        phase_d  = '0;
        en_d     = 1'b1;
        grp_d[0] = in_data;
        for (int p = 1; p < PHASES; p++) begin
          grp_d[p] = hold_q[p];
        end
      end else begin
        phase_d = phase_q + 1'b1;
        hold_d[int'(LAST - phase_q)] = in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      hold_q  <= '0;
      grp_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hold_q  <= hold_d;
      grp_q   <= grp_d;
      en_q    <= en_d;
    end
  end

  assign grp_en   = en_q;
  assign grp_data = grp_q;

  // R2: idle cycles leave the group position untouched
  a_r2_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_q));

  // R1: a group enable never lasts two cycles
  a_r1_enable_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    grp_en |=> !grp_en);

  // R1: the position counter stays inside one group
  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);

endmodule

// File: rtl/decim6_branch.sv
module decim6_branch #(
  parameter int PHASE_ID = 0,
  parameter int PHASES   = 6,
  parameter int TAPS     = 10,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int AW       = 38
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [DW-1:0]        x,
  output logic [AW-1:0]        sum
);

  logic signed [AW-1:0] prod  [TAPS];
  logic signed [AW-1:0] acc_q [TAPS];
  logic signed [AW-1:0] acc_d [TAPS];
  logic signed [AW-1:0] x_ext;

  assign x_ext = $signed({{(AW-DW){x[DW-1]}}, x});

  // One constant multiplier per tap; tap j of this branch is prototype tap PHASE_ID + PHASES*j
  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    localparam int               HV = decim6_pkg::proto_coef(PHASE_ID + PHASES * j);
    localparam logic [CW-1:0]    HC = CW'(HV);
    logic signed [AW-1:0]        h_ext;
    assign h_ext   = $signed({{(AW-CW){HC[CW-1]}}, HC});
    assign prod[j] = x_ext * h_ext;
  end

  // Registered add chain: each stage adds its product to the next stage's held partial sum
  always_comb begin
    for (int j = 0; j < TAPS - 1; j++) begin
      acc_d[j] = acc_q[j+1] + prod[j];
    end
    acc_d[TAPS-1] = prod[TAPS-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < TAPS; j++) begin
        acc_q[j] <= '0;
      end
    end else if (en) begin
      acc_q <= acc_d;
    end
  end

  assign sum = acc_q[0];

  // R2: the branch output changes only on a group enable
  a_r2_branch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sum));

endmodule

// File: rtl/decim6_combine.sv
module decim6_combine #(
  parameter int PHASES = 6,
  parameter int AW     = 38,
  parameter int OW     = 16,
  parameter int SHIFT  = 15
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [PHASES-1:0][AW-1:0]    sums,
  output logic                         out_valid,
  output logic [OW-1:0]                out_data
);

  localparam logic signed [AW-1:0] RND  = AW'(1) <<< (SHIFT - 1);
  localparam logic signed [AW-1:0] OMAX = AW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [AW-1:0] OMIN = -OMAX - AW'(1);

  logic                  v_sum_q, v_tot_q, v_out_q;
  logic signed [AW-1:0]  tot_q, tot_d;
  logic signed [AW-1:0]  rnd;
  logic [OW-1:0]         out_q, out_d;

  // Adder across all branch sums
  always_comb begin
    tot_d = '0;
    for (int p = 0; p < PHASES; p++) begin
      tot_d = tot_d + $signed(sums[p]);
    end
  end

  // Round half up, then clamp to the output range
  always_comb begin
    rnd = (tot_q + RND) >>> SHIFT;
    if (rnd > OMAX) begin
      out_d = OMAX[OW-1:0];
    end else if (rnd < OMIN) begin
      out_d = OMIN[OW-1:0];
    end else begin
      out_d = rnd[OW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_sum_q <= 1'b0;
      v_tot_q <= 1'b0;
      v_out_q <= 1'b0;
      tot_q   <= '0;
      out_q   <= '0;
    end else begin
      v_sum_q <= en;
      v_tot_q <= v_sum_q;
      v_out_q <= v_tot_q;
      if (v_sum_q) tot_q <= tot_d;
      if (v_tot_q) out_q <= out_d;
    end
  end

  assign out_valid = v_out_q;
  assign out_data  = out_q;

  // R1: each result is flagged for exactly one cycle
  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: the held result changes only when a new one is presented
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: rtl/decim6_polyfir.sv
module decim6_polyfir #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int PHASES   = decim6_pkg::PHASES_DEF,
  parameter int TAPS_PER = decim6_pkg::TAPS_PER_DEF,
  parameter int OW       = 16,
  parameter int SHIFT    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  output logic [OW-1:0]     out_data
);

  localparam int PW = DW + CW;
  localparam int AW = PW + $clog2(PHASES * TAPS_PER);

  logic                         rst_meta_n, rst_sync_n;
  logic                         grp_en;
  logic [PHASES-1:0][DW-1:0]    grp_data;
  logic [PHASES-1:0][AW-1:0]    br_sum;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  decim6_commutator #(
    .PHASES (PHASES),
    .DW     (DW)
  ) u_comm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .grp_en   (grp_en),
    .grp_data (grp_data)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_branch
    decim6_branch #(
      .PHASE_ID (p),
      .PHASES   (PHASES),
      .TAPS     (TAPS_PER),
      .DW       (DW),
      .CW       (CW),
      .AW       (AW)
    ) u_branch (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (grp_en),
      .x     (grp_data[p]),
      .sum   (br_sum[p])
    );
  end

  decim6_combine #(
    .PHASES (PHASES),
    .AW     (AW),
    .OW     (OW),
    .SHIFT  (SHIFT)
  ) u_comb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (grp_en),
    .sums      (br_sum),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // R6: a result appears exactly three edges after its group enable was raised
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(grp_en, 3));

  // R7: nothing is flagged while reset is held
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> !out_valid);

endmodule

// File: tb/decim6_polyfir_tb.sv
module decim6_polyfir_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int got_cnt = 0;
  bit done    = 1'b0;

  int hist[$];
  int exp_val[$];
  int exp_cyc[$];
  string exp_req[$];

  // Table walk: sample value and idle cycles after it
  localparam int NV = 36;
  localparam int STIM_V [NV] = '{
     1200, -3400,  5600,  -780, 32767, -32768,   250,  9100, -9100,  4444, -1, 0,
    17000, -2500,   333,  -333, 12000,  -4000,  7777, -7777,    15, -15, 30000, -30000,
      100,   200,   300,   400,   500,    600, -1000, 22222, -22222, 5, -6, 8191};
  localparam int STIM_G [NV] = '{
    0, 0, 0, 0, 0, 0,  2, 0, 1, 0, 0, 3,
    0, 0, 0, 0, 0, 0,  0, 5, 0, 0, 1, 0,
    0, 0, 0, 0, 0, 0,  4, 0, 0, 2, 0, 0};

  decim6_polyfir u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // R4: prototype tap formula
  function automatic int h_of(input int k);
    return (((k * 97 + 13) % 181) - 90) * 300;
  endfunction

  // R3/R5: full 60-tap reference at sample n
  function automatic int model_at(input int n);
    longint acc = 0;
    longint r;
    for (int k = 0; k < 60; k++) begin
      if (n - k >= 0) acc += longint'(h_of(k)) * longint'(hist[n - k]);
    end
    r = (acc + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int v, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(v);
    hist.push_back(v);
    if (hist.size() % 6 == 0) begin
      exp_val.push_back(model_at(hist.size() - 1));
      exp_cyc.push_back(cyc + 4);
      exp_req.push_back(req);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain_check();
    idle(8);
    check(exp_val.size() == 0, "R1 pending results", exp_val.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    hist.delete();
    exp_val.delete();
    exp_cyc.delete();
    exp_req.delete();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 valid in reset", int'(out_valid), 0);
    check(out_data == 16'd0, "R7 data in reset", int'($signed(out_data)), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Output monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got_cnt++;
      if (exp_val.size() == 0) begin
        check(1'b0, "R1 unexpected result", int'($signed(out_data)), 0);
      end else begin
        automatic int    ev = exp_val.pop_front();
        automatic int    ec = exp_cyc.pop_front();
        automatic string er = exp_req.pop_front();
        check(int'($signed(out_data)) == ev, er, int'($signed(out_data)), ev);
        check(cyc == ec, "R6 latency", cyc, ec);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (2) @(negedge clk);
    do_reset();

    // R3/R5/R8 table walk with mixed gaps (R2)
    for (int i = 0; i < NV; i++) begin
      push(STIM_V[i], "R3 table");
      if (STIM_G[i] > 0) idle(STIM_G[i]);
    end
    drain_check();

    // R8: continuous groups
    for (int i = 0; i < 48; i++) push((i * 2731) % 20000 - 10000, "R8 back to back");
    drain_check();

    // R2: long gaps between every sample
    for (int i = 0; i < 12; i++) begin
      push(1000 * (i + 1) - 6000, "R2 gapped");
      idle(7);
    end
    got_cnt = 0;
    idle(30);
    check(got_cnt == 0, "R2 no output while idle", got_cnt, 0);
    drain_check();

    // R3/R4: impulse at first group position
    do_reset();
    push(32767, "R4 impulse first");
    for (int i = 1; i < 72; i++) push(0, "R4 impulse first");
    drain_check();

    // R3/R4: impulse at last group position
    do_reset();
    for (int i = 0; i < 5; i++) push(0, "R3 impulse last");
    push(32767, "R3 impulse last");
    for (int i = 6; i < 72; i++) push(0, "R3 impulse last");
    drain_check();

    // R5: positive saturation, sample 59 ends group 9
    do_reset();
    for (int i = 0; i < 60; i++) push((h_of(59 - i) >= 0) ? 32767 : -32768, "R5 sat high");
    check(exp_val[exp_val.size() - 1] == 32767, "R5 model high", exp_val[exp_val.size() - 1], 32767);
    drain_check();

    // R5: negative saturation
    do_reset();
    for (int i = 0; i < 60; i++) push((h_of(59 - i) >= 0) ? -32768 : 32767, "R5 sat low");
    check(exp_val[exp_val.size() - 1] == -32768, "R5 model low", exp_val[exp_val.size() - 1], -32768);
    drain_check();

    // R7: reset in the middle of a group clears position and history
    for (int i = 0; i < 3; i++) push(20000, "R7 pre reset");
    do_reset();
    for (int i = 0; i < 18; i++) push(3000 - 400 * i, "R7 after reset");
    drain_check();

    // R1: output count for 24 inputs
    got_cnt = 0;
    for (int i = 0; i < 24; i++) push(i * 100, "R1 count");
    idle(8);
    check(got_cnt == 4, "R1 output count", got_cnt, 4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule